// File: doc/BRIEF.md
# Parallel Display Bus Master

This block lets on-chip logic talk to an external display controller over an 8-bit parallel bus. The bus uses separate read and write strobes, a chip select, a reset line and a command/data select line. All four control strobes are active low. On the host side there is a single-cycle request. The request carries a command/data flag, a read/write flag and a 16-bit word for writes. The block answers with a busy level, and after a read it returns a one-cycle valid pulse with the 16-bit result.

Every 16-bit transfer is split into two byte cycles, upper byte first. Each byte cycle has three phases. First comes one setup cycle with the strobes high. Then a strobe is driven low for a programmed number of clocks. Then comes a high recovery interval. In a read, the external bus is captured at a programmed clock count after the read strobe falls. All intervals are parameters counted in system clocks, and each must be at least one. The read sample count must not exceed the read low count. Once the local reset ends, the block drives the display reset line low for a programmed time. It then releases the line and waits a further programmed time before it takes any request.

The data pins are modelled as separate output, output-enable and input vectors, so that a pad buffer can be placed at the chip edge. An output-enable of 0 means the pins are released to high impedance.

Top module: `pbus_master`

## Requirements
- R1: After `rst` is released, `bus_rst_n` stays low for exactly POR_LOW clock cycles. After it goes high, `busy` stays high for exactly POR_WAIT more cycles. Requests made during that whole time produce no strobe. In this period `bus_cs_n`, `bus_wr_n` and `bus_rd_n` are high, `bus_dc` is 1 and `bus_d_oe` is 0.
- R2: While a request is in progress, `bus_dc` is 0 for a command request and 1 for a data request.
- R3: `bus_dc` returns to 1 in the same cycle that `busy` falls, and it stays 1 while the block is idle.
- R4: A write emits exactly two WR strobes. The first carries `req_wdata[15:8]` and the second carries `req_wdata[7:0]`. `bus_d_out` is stable for the whole time `bus_wr_n` is low.
- R5: Each WR low pulse lasts exactly WR_LOW cycles. The first pulse follows at least one cycle with chip select low and WR high. WR stays high for at least WR_IDLE cycles between the two pulses.
- R6: Each RD low pulse lasts exactly RD_LOW cycles. `bus_d_in` is captured on the clock edge RD_SAMPLE cycles after RD fell. RD stays high for at least RD_REC cycles between the two pulses.
- R7: After a read, `rd_valid` is high for exactly one cycle, starting in the cycle `busy` falls. In that cycle `rd_data` holds the first captured byte in bits 15:8 and the second in bits 7:0. A write produces no `rd_valid`.
- R8: `bus_d_oe` is 1 only during write requests. It is 0 whenever `bus_rd_n` is low and whenever `bus_cs_n` is high.
- R9: `bus_cs_n` goes low before the first strobe of a request and goes high again only when the request ends. `busy` is high for exactly 2*(1+LOW+REC) cycles per request, using the write or read intervals as fits. A request that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_is_cmd | input | 1 | 1 = command transfer, 0 = data transfer |
| req_is_read | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | High during power-up and while a request runs |
| rd_valid | output | 1 | One-cycle pulse when rd_data holds a new read result |
| rd_data | output | 16 | Assembled read word |
| bus_d_out | output | 8 | Data driven onto the bus |
| bus_d_oe | output | 1 | 1 = drive bus_d_out, 0 = high impedance |
| bus_d_in | input | 8 | Data read from the bus |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rst_n | output | 1 | Display reset, active low |
| bus_dc | output | 1 | 0 = command, 1 = data |

## Verification
A wrong phase or byte index shows up at the pins within one byte cycle. It appears as a strobe pulse of the wrong width, a third strobe or a missing one, or a second byte that repeats the first. A capture point off by one cycle returns a marker byte in place of the model's data, because the bus model presents valid data only on the exact sample clock. A stale command/data level or an output enable left on shows in the cycle `busy` falls, or during the strobes of the following request.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } pbus_phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pbus_timer.sv
module pbus_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         done
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign done = (cnt == limit - 1'b1);

endmodule

// File: rtl/pbus_por.sv
module pbus_por #(
  parameter int LOW_CYC  = 16,
  parameter int WAIT_CYC = 12
) (
  input  logic clk,
  input  logic rst,
  output logic pin_rst_n,
  output logic ready
);
  import pbus_pkg::*;

  localparam int W = $clog2(max2(LOW_CYC, WAIT_CYC) + 1);

  logic [W-1:0] cnt;
  logic         waiting;
  logic [W-1:0] lim;

  assign lim = waiting ? W'(WAIT_CYC) : W'(LOW_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      waiting   <= 1'b0;
      pin_rst_n <= 1'b0;
      ready     <= 1'b0;
    end else if (!ready) begin
      if (cnt == lim - 1'b1) begin
        cnt <= '0;
        if (!waiting) begin
          waiting   <= 1'b1;
          pin_rst_n <= 1'b1;
        end else begin
          ready <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int WORD_W    = 16,
  parameter int BUS_W     = 8,
  parameter int WR_LOW    = 2,
  parameter int WR_IDLE   = 2,
  parameter int RD_LOW    = 6,
  parameter int RD_SAMPLE = 5,
  parameter int RD_REC    = 3,
  parameter int POR_LOW   = 16,
  parameter int POR_WAIT  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_cmd,
  input  logic              req_is_read,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [BUS_W-1:0]  bus_d_out,
  output logic              bus_d_oe,
  input  logic [BUS_W-1:0]  bus_d_in,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_cs_n,
  output logic              bus_rst_n,
  output logic              bus_dc
);
  import pbus_pkg::*;

  localparam int NBYTES  = WORD_W / BUS_W;
  localparam int IDX_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int CNT_MAX = max2(max2(WR_LOW, WR_IDLE), max2(max2(RD_LOW, RD_REC), RD_SAMPLE));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  pbus_phase_e       phase_q;
  logic              is_rd_q;
  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] wsr_q;
  logic [WORD_W-1:0] rsr_q;
  logic              ready;

  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  cnt;
  logic              done;
  logic              advance;
  logic              tmr_clr;
  logic              sample;
  logic              accept;
  logic              last_byte;

  pbus_por #(
    .LOW_CYC  (POR_LOW),
    .WAIT_CYC (POR_WAIT)
  ) u_por (
    .clk       (clk),
    .rst       (rst),
    .pin_rst_n (bus_rst_n),
    .ready     (ready)
  );

  pbus_timer #(
    .W (CNT_W)
  ) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .limit (limit),
    .cnt   (cnt),
    .done  (done)
  );

  always_comb begin
    if (phase_q == PH_STROBE) limit = is_rd_q ? CNT_W'(RD_LOW) : CNT_W'(WR_LOW);
    else                      limit = is_rd_q ? CNT_W'(RD_REC) : CNT_W'(WR_IDLE);
  end

  assign advance   = ((phase_q == PH_STROBE) || (phase_q == PH_RECOV)) && done;
  assign tmr_clr   = advance || (phase_q == PH_IDLE) || (phase_q == PH_SETUP);
  assign sample    = (phase_q == PH_STROBE) && is_rd_q && (cnt == CNT_W'(RD_SAMPLE - 1));
  assign accept    = req_valid && ready && (phase_q == PH_IDLE);
  assign last_byte = (idx_q == IDX_W'(NBYTES - 1));
  assign busy      = !ready || active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      is_rd_q   <= 1'b0;
      active_q  <= 1'b0;
      idx_q     <= '0;
      wsr_q     <= '0;
      rsr_q     <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      bus_d_out <= '0;
      bus_d_oe  <= 1'b0;
      bus_rd_n  <= 1'b1;
      bus_wr_n  <= 1'b1;
      bus_cs_n  <= 1'b1;
      bus_dc    <= 1'b1;
    end else begin
      rd_valid <= 1'b0;
      if (sample) rsr_q <= (rsr_q << BUS_W) | WORD_W'(bus_d_in);
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q   <= PH_SETUP;
            active_q  <= 1'b1;
            is_rd_q   <= req_is_read;
            idx_q     <= '0;
            bus_cs_n  <= 1'b0;
            bus_dc    <= !req_is_cmd;
            bus_d_oe  <= !req_is_read;
            bus_d_out <= req_wdata[WORD_W-1 -: BUS_W];
            wsr_q     <= req_wdata << BUS_W;
          end
        end
        PH_SETUP: begin
          phase_q <= PH_STROBE;
          if (is_rd_q) bus_rd_n <= 1'b0;
          else         bus_wr_n <= 1'b0;
        end
        PH_STROBE: begin
          if (done) begin
            bus_rd_n <= 1'b1;
            bus_wr_n <= 1'b1;
            phase_q  <= PH_RECOV;
          end
        end
        PH_RECOV: begin
          if (done) begin
            if (last_byte) begin
              phase_q  <= PH_IDLE;
              active_q <= 1'b0;
              bus_cs_n <= 1'b1;
              bus_dc   <= 1'b1;
              bus_d_oe <= 1'b0;
              rd_valid <= is_rd_q;
              if (is_rd_q) rd_data <= rsr_q;
            end else begin
              phase_q   <= PH_SETUP;
              idx_q     <= idx_q + 1'b1;
              bus_d_out <= wsr_q[WORD_W-1 -: BUS_W];
              wsr_q     <= wsr_q << BUS_W;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             rd_valid,
  input logic [BUS_W-1:0] bus_d_out,
  input logic             bus_d_oe,
  input logic             bus_rd_n,
  input logic             bus_wr_n,
  input logic             bus_cs_n,
  input logic             bus_rst_n,
  input logic             bus_dc
);

  // R8
  oe_off_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_d_oe);

  // R8
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    bus_d_oe |-> !bus_cs_n);

  // R9
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr_n || bus_rd_n);

  // R1
  por_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rst_n |-> (bus_cs_n && busy));

  // R3
  dc_cmd_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_dc |-> !bus_cs_n);

  // R4
  wr_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n && $past(!bus_wr_n)) |-> $stable(bus_d_out));

  // R7
  rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

bind pbus_master pbus_master_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .bus_d_out (bus_d_out),
  .bus_d_oe  (bus_d_oe),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_cs_n  (bus_cs_n),
  .bus_rst_n (bus_rst_n),
  .bus_dc    (bus_dc)
);

// File: tb/pbus_master_tb.sv
`timescale 1ns/1ps
module pbus_master_tb;

  localparam int WR_LOW = 2, WR_IDLE = 2, RD_LOW = 6, RD_SAMPLE = 5, RD_REC = 3;
  localparam int POR_LOW = 16, POR_WAIT = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_is_cmd = 1'b0, req_is_read = 1'b0;
  logic [15:0] req_wdata = '0;
  logic busy, rd_valid, bus_d_oe, bus_rd_n, bus_wr_n, bus_cs_n, bus_rst_n, bus_dc;
  logic [15:0] rd_data;
  logic [7:0] bus_d_out, bus_d_in;

  always #2.5 clk = ~clk;

  pbus_master #(.WR_LOW(WR_LOW), .WR_IDLE(WR_IDLE), .RD_LOW(RD_LOW), .RD_SAMPLE(RD_SAMPLE),
                .RD_REC(RD_REC), .POR_LOW(POR_LOW), .POR_WAIT(POR_WAIT)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_cmd(req_is_cmd),
    .req_is_read(req_is_read), .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_cs_n(bus_cs_n), .bus_rst_n(bus_rst_n),
    .bus_dc(bus_dc));

  // display model: valid data only on the exact sample clock
  logic [15:0] model_word = '0;
  int   low_cnt = 0;
  logic rd_prev = 1'b1, rd_idx = 1'b0;
  always @(posedge clk) begin
    low_cnt <= bus_rd_n ? 0 : low_cnt + 1;
    rd_prev <= bus_rd_n;
    if (bus_cs_n) rd_idx <= 1'b0;
    else if (!rd_prev && bus_rd_n) rd_idx <= 1'b1;
  end
  assign bus_d_in = (!bus_rd_n && low_cnt == RD_SAMPLE - 1) ?
                    (rd_idx ? model_word[7:0] : model_word[15:8]) : 8'hEE;

  // bus monitor
  int wr_total = 0, rd_total = 0, bus_err = 0;
  int wr_run = 0, rd_run = 0, wr_hi = 0, rd_hi = 0;
  logic [7:0] wr_sav;
  logic       wr_dcs, rd_dcs;
  logic [7:0] wr_byte [64];
  int         wr_w [64], wr_gap [64], rd_w [64], rd_gap [64];
  logic       wr_dc [64], rd_dc [64];

  always @(negedge clk) begin
    if ((bus_d_oe && !bus_rd_n) || (bus_d_oe && bus_cs_n) || (!bus_d_oe && !bus_wr_n) ||
        (bus_cs_n && (!bus_wr_n || !bus_rd_n)))
      bus_err = bus_err + 1;
    if (!bus_wr_n) begin
      if (wr_run == 0) begin wr_gap[wr_total % 64] = wr_hi; wr_sav = bus_d_out; wr_dcs = bus_dc; end
      else if (bus_d_out !== wr_sav || bus_dc !== wr_dcs) bus_err = bus_err + 1;
      wr_run = wr_run + 1;
    end else begin
      if (wr_run > 0) begin
        wr_byte[wr_total % 64] = wr_sav; wr_w[wr_total % 64] = wr_run;
        wr_dc[wr_total % 64] = wr_dcs; wr_total = wr_total + 1; wr_run = 0; wr_hi = 0;
      end
      wr_hi = bus_cs_n ? 0 : wr_hi + 1;
    end
    if (!bus_rd_n) begin
      if (rd_run == 0) begin rd_gap[rd_total % 64] = rd_hi; rd_dcs = bus_dc; end
      rd_run = rd_run + 1;
    end else begin
      if (rd_run > 0) begin
        rd_w[rd_total % 64] = rd_run; rd_dc[rd_total % 64] = rd_dcs;
        rd_total = rd_total + 1; rd_run = 0; rd_hi = 0;
      end
      rd_hi = bus_cs_n ? 0 : rd_hi + 1;
    end
  end

  int compared = 0, mismatched = 0;
  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {is_cmd, is_read, write word, model read word}
  localparam logic [33:0] VEC [0:5] = '{
    {1'b1, 1'b0, 16'hA55A, 16'h0000},
    {1'b0, 1'b0, 16'h1234, 16'h0000},
    {1'b0, 1'b1, 16'h0000, 16'hBEEF},
    {1'b1, 1'b1, 16'h0000, 16'h00FF},
    {1'b0, 1'b0, 16'hFF00, 16'h0000},
    {1'b0, 1'b1, 16'h0000, 16'h5AC3}
  };

  task automatic issue(input logic cmd, input logic rd, input logic [15:0] w);
    @(negedge clk);
    req_is_cmd = cmd; req_is_read = rd; req_wdata = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    int n, w0, r0, e0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 idle cs_n", bus_cs_n, 1);
    chk("R1 idle wr_n/rd_n", {bus_wr_n, bus_rd_n}, 2'b11);
    chk("R1 idle dc", bus_dc, 1);
    chk("R1 idle oe", bus_d_oe, 0);
    chk("R1 busy at reset", busy, 1);
    n = 0;
    while (!bus_rst_n) begin
      if (n == 5) begin req_is_read = 1'b0; req_wdata = 16'hDEAD; req_valid = 1'b1; end
      else req_valid = 1'b0;
      @(negedge clk); n++;
    end
    req_valid = 1'b0;
    chk("R1 reset pulse length", n, POR_LOW);
    n = 0;
    while (busy) begin
      if (n == 2) req_valid = 1'b1; else req_valid = 1'b0;
      n++; @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R1 startup wait length", n, POR_WAIT);
    repeat (4) @(negedge clk);
    chk("R1 no strobe during power-up", wr_total + rd_total, 0);

    for (int v = 0; v < 6; v++) begin
      logic cmd, rd; logic [15:0] w, m;
      {cmd, rd, w, m} = VEC[v];
      model_word = m;
      w0 = wr_total; r0 = rd_total; e0 = bus_err;
      issue(cmd, rd, w);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R9 busy length", n, rd ? 2 * (1 + RD_LOW + RD_REC) : 2 * (1 + WR_LOW + WR_IDLE));
      chk("R3 dc back to data", bus_dc, 1);
      chk("R9 cs released", bus_cs_n, 1);
      chk("R8 bus activity rules", bus_err - e0, 0);
      if (!rd) begin
        chk("R4 write strobe count", wr_total - w0, 2);
        chk("R4 high byte first", wr_byte[w0 % 64], w[15:8]);
        chk("R4 low byte second", wr_byte[(w0 + 1) % 64], w[7:0]);
        chk("R2 dc during write", {wr_dc[w0 % 64], wr_dc[(w0 + 1) % 64]}, {2{!cmd}});
        chk("R5 wr low width b0", wr_w[w0 % 64], WR_LOW);
        chk("R5 wr low width b1", wr_w[(w0 + 1) % 64], WR_LOW);
        chk("R5 setup before first wr", int'(wr_gap[w0 % 64] >= 1), 1);
        chk("R5 wr idle between", int'(wr_gap[(w0 + 1) % 64] >= WR_IDLE), 1);
        chk("R7 no rd_valid on write", rd_valid, 0);
      end else begin
        chk("R6 read strobe count", rd_total - r0, 2);
        chk("R6 rd low width b0", rd_w[r0 % 64], RD_LOW);
        chk("R6 rd low width b1", rd_w[(r0 + 1) % 64], RD_LOW);
        chk("R6 rd recovery", int'(rd_gap[(r0 + 1) % 64] >= RD_REC), 1);
        chk("R2 dc during read", {rd_dc[r0 % 64], rd_dc[(r0 + 1) % 64]}, {2{!cmd}});
        chk("R7 rd_valid", rd_valid, 1);
        chk("R7 rd_data order", rd_data, m);
        chk("R8 no write strobe on read", wr_total - w0, 0);
        @(negedge clk);
        chk("R7 rd_valid one cycle", rd_valid, 0);
      end
    end

    // R9 directed: second request during busy is ignored
    w0 = wr_total;
    issue(1'b0, 1'b0, 16'h0F0F);
    repeat (2) @(negedge clk);
    req_is_cmd = 1'b1; req_wdata = 16'hF0F0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R9 ignored request strobes", wr_total - w0, 2);
    chk("R9 ignored request data", {wr_byte[w0 % 64], wr_byte[(w0 + 1) % 64]}, 16'h0F0F);
    chk("R9 ignored request dc", {wr_dc[w0 % 64], wr_dc[(w0 + 1) % 64]}, 2'b11);
    chk("R3 dc idle high", bus_dc, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule